// File: doc/BRIEF.md
# Serial Register Write Slave

This block receives register writes over a three-line serial link: a serial clock, a serial data line and an active-low frame select. While the select is low, each rising edge of the serial clock delivers one bit. The first eight bits of a frame form a register address. Every group of twenty-four bits after that forms one data word. Both fields arrive least significant bit first.

Each completed data word turns into a single-cycle write strobe in the system clock domain, together with an address and a data value. The first word of a frame goes to the address that was sent. Each later word in the same frame goes to the next higher address, so software can fill a run of registers without sending the address again. A word that is cut short by the end of the frame is dropped.

All three serial lines pass through two-flop synchronizers, and serial clock edges are detected in the system clock domain. The system clock must therefore run at least four times faster than the serial clock.

Top module: `ser_wr_slave`

## Requirements
- R1: After reset, wr_strobe_o is 0 and wr_addr_o and wr_data_o are 0.
- R2: In a frame, the first 8 bits taken on serial clock rising edges are the address, least significant bit first. Each following group of 24 bits is a data word, least significant bit first.
- R3: Every complete data word produces exactly one write: wr_strobe_o is high for one system clock cycle, and at the same time wr_addr_o and wr_data_o show that word's target address and data.
- R4: If the frame select goes high before all 24 bits of a data word have arrived, that word produces no write. A frame that carries only the address, or only part of it, produces no write.
- R5: Each complete word after the first in a frame is written to the previous word's address plus one.
- R6: The address counter wraps from 0xFF to 0x00 when it increments.
- R7: Serial clock rising edges while the frame select is high have no effect. The serial clock may idle high or low between frames.
- R8: wr_addr_o and wr_data_o hold their values from one write strobe until the next.
- R9: A serial clock rising edge that reaches the system domain in the same cycle as the frame select's rising edge is discarded.
- R10: The end of a frame clears the bit count and the address/data phase, whatever state the block was in. The next frame starts again with an 8-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdat_i | input | 1 | Serial data |
| sel_n_i | input | 1 | Frame select, active low |
| wr_strobe_o | output | 1 | Single-cycle write pulse |
| wr_addr_o | output | 8 | Address of the current write |
| wr_data_o | output | 24 | Data of the current write |

## Verification
Two events can reach the deserializer in the same system cycle: the end of a frame and the serial clock edge that carries the last bit of a word. The bench raises the serial clock for bit 24 at exactly the moment it releases the frame select. Both lines pass through synchronizers of equal depth, so the two events arrive together. The run is judged correct if no write appears, and if a normal frame sent right afterwards lands at its own address. That shows the end of the frame won and left nothing half-finished behind.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int unsigned SWR_AW = 8;
  localparam int unsigned SWR_DW = 24;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } swr_phase_e;
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
  parameter int unsigned     STAGES = 2,
  parameter int unsigned     W      = 1,
  parameter logic [W-1:0]    RST_V  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[s] <= RST_V;
      end else if (s == 0) begin
        chain[s] <= d_i;
      end else begin
        chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/swr_edge.sv
module swr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic sel_s,
  output logic sclk_rise,
  output logic sel_rise
);
  logic sclk_q;
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      sel_q  <= sel_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sel_rise  = sel_s & ~sel_q;
endmodule

// File: rtl/swr_deser.sv
module swr_deser
  import swr_pkg::*;
#(
  parameter int unsigned AW = SWR_AW,
  parameter int unsigned DW = SWR_DW,
  localparam int unsigned CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_rise,
  input  logic          sdat_s,
  input  logic          sel_s,
  output logic          bit_take,
  output logic [CW-1:0] bit_cnt,
  output swr_phase_e    phase,
  output logic          addr_ld,
  output logic [AW-1:0] addr_val,
  output logic          word_done,
  output logic [DW-1:0] word_val
);
  logic [DW-1:0] shreg;
  logic [DW-1:0] shreg_nxt;

  // shift a new bit in at the top; after n shifts the last n bits sit in
  // the upper n positions with the first-received bit lowest
  function automatic logic [DW-1:0] shift_lsb_first(input logic [DW-1:0] cur,
                                                     input logic b);
    return {b, cur[DW-1:1]};
  endfunction

  function automatic logic [AW-1:0] addr_field(input logic [DW-1:0] sr);
    return sr[DW-1 -: AW];
  endfunction

  assign bit_take  = sclk_rise & ~sel_s;
  assign shreg_nxt = shift_lsb_first(shreg, sdat_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      phase     <= PH_ADDR;
      addr_ld   <= 1'b0;
      addr_val  <= '0;
      word_done <= 1'b0;
      word_val  <= '0;
    end else begin
      addr_ld   <= 1'b0;
      word_done <= 1'b0;
      if (sel_s) begin
        bit_cnt <= '0;
        phase   <= PH_ADDR;
      end else if (bit_take) begin
        shreg <= shreg_nxt;
        if (phase == PH_ADDR) begin
          if (bit_cnt == CW'(AW - 1)) begin
            addr_ld  <= 1'b1;
            addr_val <= addr_field(shreg_nxt);
            bit_cnt  <= '0;
            phase    <= PH_DATA;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          if (bit_cnt == CW'(DW - 1)) begin
            word_done <= 1'b1;
            word_val  <= shreg_nxt;
            bit_cnt   <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/swr_wrport.sv
module swr_wrport #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_val,
  input  logic          word_done,
  input  logic [DW-1:0] word_val,
  output logic [AW-1:0] addr_cnt,
  output logic          wr_strobe,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  // modulo-2^AW step: 0xFF wraps to 0x00 for AW = 8
  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_cnt  <= '0;
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_strobe <= word_done;
      if (addr_ld) begin
        addr_cnt <= addr_val;
      end else if (word_done) begin
        wr_addr  <= addr_cnt;
        wr_data  <= word_val;
        addr_cnt <= addr_step(addr_cnt);
      end
    end
  end
endmodule

// File: rtl/ser_wr_slave.sv
module ser_wr_slave
  import swr_pkg::*;
#(
  parameter int unsigned AW          = SWR_AW,
  parameter int unsigned DW          = SWR_DW,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          sdat_i,
  input  logic          sel_n_i,
  output logic          wr_strobe_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic          sclk_s;
  logic          sdat_s;
  logic          sel_s;
  logic          sclk_rise;
  logic          sel_rise;
  logic          bit_take;
  logic [CW-1:0] bit_cnt;
  swr_phase_e    phase;
  logic          addr_ld;
  logic [AW-1:0] addr_val;
  logic          word_done;
  logic [DW-1:0] word_val;
  logic [AW-1:0] addr_cnt;
  logic [2:0]    sync_q;

  swr_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_V(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sel_n_i, sdat_i, sclk_i}),
    .q_o   (sync_q)
  );

  assign sclk_s = sync_q[0];
  assign sdat_s = sync_q[1];
  assign sel_s  = sync_q[2];

  swr_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .sel_s     (sel_s),
    .sclk_rise (sclk_rise),
    .sel_rise  (sel_rise)
  );

  swr_deser #(.AW(AW), .DW(DW)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (sclk_rise),
    .sdat_s    (sdat_s),
    .sel_s     (sel_s),
    .bit_take  (bit_take),
    .bit_cnt   (bit_cnt),
    .phase     (phase),
    .addr_ld   (addr_ld),
    .addr_val  (addr_val),
    .word_done (word_done),
    .word_val  (word_val)
  );

  swr_wrport #(.AW(AW), .DW(DW)) u_wrport (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_ld   (addr_ld),
    .addr_val  (addr_val),
    .word_done (word_done),
    .word_val  (word_val),
    .addr_cnt  (addr_cnt),
    .wr_strobe (wr_strobe_o),
    .wr_addr   (wr_addr_o),
    .wr_data   (wr_data_o)
  );
endmodule

// File: rtl/swr_chk.sv
module swr_chk
  import swr_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 24,
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_strobe,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          addr_ld,
  input logic          word_done,
  input logic          sel_s,
  input logic          sel_rise,
  input logic          bit_take,
  input logic [CW-1:0] bit_cnt,
  input swr_phase_e    phase
);
  logic          chained;
  logic [AW-1:0] last_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chained   <= 1'b0;
      last_addr <= '0;
    end else if (addr_ld) begin
      chained <= 1'b0;
    end else if (wr_strobe) begin
      chained   <= 1'b1;
      last_addr <= wr_addr;
    end
  end

  p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  p_word_to_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> wr_strobe);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> ($stable(wr_addr) && $stable(wr_data)));

  // R5 and R6: consecutive writes of one frame step the address modulo 2^AW
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && chained) |-> (wr_addr == AW'(last_addr + 1'b1)));

  p_idle_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |-> !bit_take);

  p_frame_end_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> (bit_cnt == '0 && phase == PH_ADDR));
endmodule

bind ser_wr_slave swr_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_strobe (wr_strobe_o),
  .wr_addr   (wr_addr_o),
  .wr_data   (wr_data_o),
  .addr_ld   (addr_ld),
  .word_done (word_done),
  .sel_s     (sel_s),
  .sel_rise  (sel_rise),
  .bit_take  (bit_take),
  .bit_cnt   (bit_cnt),
  .phase     (phase)
);

// File: tb/sim_ser_wr_slave.sv
`timescale 1ns/1ps
module sim_ser_wr_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sdat = 1'b0;
  logic        sel_n = 1'b1;
  logic        wr_strobe;
  logic [7:0]  wr_addr;
  logic [23:0] wr_data;

  int checks = 0;
  int errors = 0;

  logic [7:0]  log_a [32];
  logic [23:0] log_d [32];
  int          n_log = 0;
  logic        prev_strobe = 1'b0;

  always #2.5 clk = ~clk;

  ser_wr_slave u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_i      (sclk),
    .sdat_i      (sdat),
    .sel_n_i     (sel_n),
    .wr_strobe_o (wr_strobe),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data)
  );

  // monitor away from the active edge: record writes, police strobe width (R3)
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_strobe && prev_strobe) begin
        errors++;
        $display("FAIL R3 strobe width: actual 2+ cycles expected 1");
      end
      if (wr_strobe && n_log < 32) begin
        log_a[n_log] = wr_addr;
        log_d[n_log] = wr_data;
        n_log++;
      end
      prev_strobe = wr_strobe;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b0; sdat = b; #20;
    sclk = 1'b1; #20;
  endtask

  task automatic send_bits(input logic [23:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic frame_open();
    sel_n = 1'b0; #30;
  endtask

  task automatic frame_close();
    #20 sel_n = 1'b1; #150;
  endtask

  task automatic clear_log();
    n_log = 0;
  endtask

  task automatic expect_n(input int n, input string req);
    chk(n_log == n, req, "write count", n_log, n);
  endtask

  task automatic expect_w(input int i, input logic [7:0] a, input logic [23:0] d,
                          input string req);
    chk(log_a[i] == a, req, "address", {24'h0, log_a[i]}, {24'h0, a});
    chk(log_d[i] == d, req, "data", {8'h0, log_d[i]}, {8'h0, d});
  endtask

  task automatic t_reset();
    chk(wr_strobe == 1'b0, "R1", "strobe", {31'h0, wr_strobe}, 0);
    chk(wr_addr == 8'h0, "R1", "addr", {24'h0, wr_addr}, 0);
    chk(wr_data == 24'h0, "R1", "data", {8'h0, wr_data}, 0);
  endtask

  task automatic t_single();
    clear_log();
    frame_open(); send_bits(24'h00005A, 8); send_bits(24'hC3A5F1, 24); frame_close();
    expect_n(1, "R3");
    expect_w(0, 8'h5A, 24'hC3A5F1, "R2");
  endtask

  task automatic t_burst();
    clear_log();
    frame_open(); send_bits(24'h000010, 8);
    send_bits(24'h111111, 24); send_bits(24'h800001, 24); send_bits(24'h0F0F0F, 24);
    frame_close();
    expect_n(3, "R5");
    expect_w(0, 8'h10, 24'h111111, "R5");
    expect_w(1, 8'h11, 24'h800001, "R5");
    expect_w(2, 8'h12, 24'h0F0F0F, "R5");
  endtask

  task automatic t_wrap();
    clear_log();
    frame_open(); send_bits(24'h0000FE, 8);
    send_bits(24'hAAAAAA, 24); send_bits(24'h555555, 24); send_bits(24'h123456, 24);
    frame_close();
    expect_n(3, "R6");
    expect_w(1, 8'hFF, 24'h555555, "R6");
    expect_w(2, 8'h00, 24'h123456, "R6");
  endtask

  task automatic t_partial();
    clear_log();
    frame_open(); send_bits(24'h000020, 8);
    send_bits(24'hABCDEF, 24); send_bits(24'h3FF, 10);
    frame_close();
    expect_n(1, "R4");
    expect_w(0, 8'h20, 24'hABCDEF, "R4");
    chk(wr_addr == 8'h20, "R8", "held addr", {24'h0, wr_addr}, 32'h20);
    chk(wr_data == 24'hABCDEF, "R8", "held data", {8'h0, wr_data}, 32'hABCDEF);
    clear_log();
    frame_open(); send_bits(24'h000077, 8); frame_close();
    expect_n(0, "R4");
  endtask

  task automatic t_idle_noise();
    clear_log();
    for (int i = 0; i < 12; i++) send_bit(i[0]);
    sclk = 1'b1; #40;
    frame_open(); send_bits(24'h000033, 8); send_bits(24'h00BEEF, 24); frame_close();
    expect_n(1, "R7");
    expect_w(0, 8'h33, 24'h00BEEF, "R7");
  endtask

  task automatic t_coincident();
    clear_log();
    frame_open(); send_bits(24'h000040, 8); send_bits(24'h7FFFFF, 23);
    sclk = 1'b0; sdat = 1'b1; #20;
    sclk = 1'b1; sel_n = 1'b1; #150;
    expect_n(0, "R9");
    frame_open(); send_bits(24'h000041, 8); send_bits(24'h000ACE, 24); frame_close();
    expect_n(1, "R9");
    expect_w(0, 8'h41, 24'h000ACE, "R9");
  endtask

  task automatic t_abort();
    clear_log();
    frame_open(); send_bits(24'h00001F, 5); frame_close();
    frame_open(); send_bits(24'h000062, 8); send_bits(24'h00000C, 17); frame_close();
    frame_open(); send_bits(24'h000063, 8); send_bits(24'hF00D01, 24); frame_close();
    expect_n(1, "R10");
    expect_w(0, 8'h63, 24'hF00D01, "R10");
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #33 rst_n = 1'b1;
    #20;
    t_reset();
    t_single();
    t_burst();
    t_wrap();
    t_partial();
    t_idle_noise();
    t_coincident();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule